// File: doc/BRIEF.md
# Timeslot-16 Common Signalling Insert/Extract

This block serves timeslot 16 of a 32-slot, 2.048 Mbit/s frame when common channel signalling is in use. On the transmit side it runs from the 4.096 MHz system clock. It forwards the system-side serial stream to the line serialiser, one bit every two system clocks. Slot 16 comes either from that same stream or from a separate 64 kbit/s serial input. The serial input is strobed with a 64 kHz clock that the block divides down from the system clock and drives out.

On the receive side it runs from the recovered 2.048 MHz line clock. It takes the eight bits of slot 16 from the incoming line stream and plays them back over the following frame on a 64 kbit/s serial output. A 64 kHz clock, divided from the line clock and in step with that output, is driven next to it. Both sides count frames from their own reset release. A mode input turns the common signalling function on. With the mode off, the transmit path passes every slot through unchanged and the receive serial output rests low.

Top module: `sig_ts16_ccs`

## Requirements
- R1: The transmit frame counter holds 0 during reset, is 0 at the first sys_clk edge after sys_rst_n rises, and wraps 511 to 0. A system bit b (0..255) is taken from sys_data_i on the edge where the counter equals 2b. With ccs_en_i low, that bit appears on tx_line_o one cycle later and stays until the next bit. This holds for every slot, including slot 16. The same path applies to the slots other than 16 in every mode.
- R2: With ccs_en_i high and tx_src_sel_i low, slot 16 (system bits 128..135) is also taken from sys_data_i.
- R3: With ccs_en_i high and tx_src_sel_i high, slot 16 bit j (bit 128+j) carries the j-th serial bit taken during the previous transmit frame, counting from 0, so the first bit taken goes out first. In the first frame after reset these bits are 0.
- R4: tx_sig_clk_o has a period of 64 sys_clk cycles. It is high while the transmit counter modulo 64 is 0..31 and low for 32..63, which gives 8 periods per frame aligned to the frame start.
- R5: sig_ser_i is taken once per tx_sig_clk_o period, on the edge where the counter modulo 64 equals 16. A change later in the same period has no effect on the bit that is sent.
- R6: The receive counter holds 0 during reset, is 0 at the first rx_clk edge after rx_rst_n rises, and wraps 255 to 0. rx_sig_clk_o is high while that counter modulo 32 is 0..15 and low for 16..31.
- R7: The bits that arrive on rx_line_i at receive counts 128..135 are replayed during the next frame on rx_sig_data_o, earliest first. Bit j is loaded on the edge where the count equals 32j+15, so it changes together with the falling edge of rx_sig_clk_o, and it holds for 32 rx_clk cycles.
- R8: While ccs_en_i is low, rx_sig_data_o is driven low on every rx_clk edge. After the mode returns, the output stays low until the next load edge.
- R9: In reset, tx_line_o and rx_sig_data_o are 0 and both 64 kHz clock outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | 4.096 MHz system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, transmit side |
| rx_clk | input | 1 | Recovered 2.048 MHz line clock |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive side |
| ccs_en_i | input | 1 | 1 = common signalling mode, 0 = associated signalling (pass-through) |
| tx_src_sel_i | input | 1 | Slot-16 source in common mode: 0 = system stream, 1 = serial input |
| sys_data_i | input | 1 | System-side transmit bit stream |
| sig_ser_i | input | 1 | 64 kbit/s serial signalling input |
| tx_line_o | output | 1 | Transmit bit stream towards the line serialiser |
| tx_sig_clk_o | output | 1 | 64 kHz strobe clock for sig_ser_i |
| rx_line_i | input | 1 | Received line bit stream |
| rx_sig_data_o | output | 1 | 64 kbit/s serial output of received slot 16 |
| rx_sig_clk_o | output | 1 | 64 kHz clock in step with rx_sig_data_o |

## Verification
The bench builds the block with its default parameters: 32 slots of 8 bits, signalling in slot 16, two system clocks per line bit. With these values the divide ratios are 64 and 32, and every frame boundary, slot-16 window and load edge falls where it does on the real line. Twelve frames of both domains cover each mode and each source selection, plus mode switches at frame edges. They also cover the one-frame latency of both buffers, with marker bytes that expose bit order. In later frames the serial input is flipped after its strobe point, which makes the sampling phase visible.

// File: rtl/sig_ts16_pkg.sv
// Shared types for the timeslot-16 signalling block.
// Assumes: the slot-16 source select is a single configuration bit.
package sig_ts16_pkg;

    // Where transmit slot 16 is taken from when common signalling is on
    typedef enum logic {
        TS16_FROM_SYSTEM = 1'b0,
        TS16_FROM_SERIAL = 1'b1
    } ts16_src_e;

endpackage

// File: rtl/sig_frame_counter.sv
// Free-running frame position counter, 0 .. LEN-1.
// Assumes: LEN >= 2 and CW wide enough to hold LEN-1.
module sig_frame_counter #(
    parameter int LEN = 256,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o
);

    // Advance once per clock, wrap at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_o <= '0;
        else if (cnt_o == CW'(LEN-1)) cnt_o <= '0;
        else                          cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/sig_ts16_tx.sv
// Transmit side: gathers one serial signalling byte per frame on a divided
// 64 kHz strobe and, in common mode with the serial source chosen, puts the
// byte from the previous frame into slot SIG_SLOT, first bit first.
// Assumes: cnt_i is the frame position in system clocks (0 .. TX_FRAME-1).
module sig_ts16_tx
    import sig_ts16_pkg::*;
#(
    parameter int SLOTS       = 32,
    parameter int BITS        = 8,
    parameter int SIG_SLOT    = 16,
    parameter int SYS_PER_BIT = 2,
    parameter int CW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          ccs_en_i,
    input  ts16_src_e     src_i,
    input  logic          sys_data_i,
    input  logic          sig_ser_i,
    output logic          tx_line_o,
    output logic          sig_clk_o
);

    localparam int TX_FRAME  = SLOTS * BITS * SYS_PER_BIT;
    localparam int TX_DIV    = SYS_PER_BIT * SLOTS;
    localparam int HALF      = TX_DIV / 2;
    localparam int SAMPLE_PH = HALF / 2;
    localparam int BW        = $clog2(BITS);

    int             cnt_int;
    int             ph_int;
    int             bit_int;
    logic           bit_en;
    logic           in_sig;
    logic [BW-1:0]  bsel;
    logic [BITS-1:0] shreg;
    logic [BITS-1:0] hold;

    // Decode frame position into phase, bit strobe and slot window
    always_comb begin
        cnt_int   = int'(cnt_i);
        ph_int    = cnt_int % TX_DIV;
        bit_int   = cnt_int / SYS_PER_BIT;
        bit_en    = (cnt_int % SYS_PER_BIT) == 0;
        in_sig    = (bit_int / BITS) == SIG_SLOT;
        bsel      = BW'(BITS - 1 - (bit_int % BITS));
        sig_clk_o = ph_int < HALF;
    end

    // Gather serial bits at mid-high of each 64 kHz period
    always_ff @(posedge clk) begin
        if (!rst_n)                  shreg <= '0;
        else if (ph_int == SAMPLE_PH) shreg <= {shreg[BITS-2:0], sig_ser_i};
    end

    // Hand the gathered byte to the next frame at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold <= '0;
        else if (cnt_int == TX_FRAME - 1) hold <= shreg;
    end

    // Drive the line bit: held byte in the signalling slot, else system data
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_line_o <= 1'b0;
        else if (bit_en)
            tx_line_o <= (ccs_en_i && src_i == TS16_FROM_SERIAL && in_sig)
                         ? hold[bsel] : sys_data_i;
    end

    // R1: pass-through with common mode off
    a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !ccs_en_i) |=> (tx_line_o == $past(sys_data_i)));

    // R2: system source in common mode
    a_r2_system_src: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && ccs_en_i && src_i == TS16_FROM_SYSTEM) |=> (tx_line_o == $past(sys_data_i)));

    // R3: the handed-over byte stays put for a whole frame
    a_r3_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_int != TX_FRAME - 1) |=> $stable(hold));

    // R4: the strobe clock rises only at a period start
    a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_clk_o) |-> (ph_int == 0));

endmodule

// File: rtl/sig_ts16_rx.sv
// Receive side: captures slot SIG_SLOT from the line stream and replays it
// over the next frame on a 64 kbit/s output that changes with the falling
// edge of a divided 64 kHz clock.
// Assumes: cnt_i is the frame position in line clocks (0 .. SLOTS*BITS-1).
module sig_ts16_rx #(
    parameter int SLOTS    = 32,
    parameter int BITS     = 8,
    parameter int SIG_SLOT = 16,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          ccs_en_i,
    input  logic          line_i,
    output logic          sig_data_o,
    output logic          sig_clk_o
);

    localparam int RX_FRAME = SLOTS * BITS;
    localparam int RX_DIV   = SLOTS;
    localparam int HALF     = RX_DIV / 2;
    localparam int BW       = $clog2(BITS);

    int              cnt_int;
    int              ph_int;
    logic            in_sig;
    logic            load_en;
    logic [BW-1:0]   osel;
    logic [BITS-1:0] shreg;
    logic [BITS-1:0] hold;

    // Decode frame position into phase, slot window and output pointer
    always_comb begin
        cnt_int   = int'(cnt_i);
        ph_int    = cnt_int % RX_DIV;
        in_sig    = (cnt_int / BITS) == SIG_SLOT;
        load_en   = ph_int == HALF - 1;
        osel      = BW'(BITS - 1 - (cnt_int / RX_DIV));
        sig_clk_o = ph_int < HALF;
    end

    // Shift in the signalling slot bits as they arrive
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (in_sig) shreg <= {shreg[BITS-2:0], line_i};
    end

    // Hand the captured byte to the next frame at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold <= '0;
        else if (cnt_int == RX_FRAME - 1) hold <= shreg;
    end

    // Replay one bit per period, changing as the 64 kHz clock falls
    always_ff @(posedge clk) begin
        if (!rst_n)        sig_data_o <= 1'b0;
        else if (!ccs_en_i) sig_data_o <= 1'b0;
        else if (load_en)   sig_data_o <= hold[osel];
    end

    // R7: output changes only together with a falling receive clock
    a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ccs_en_i) && !$stable(sig_data_o)) |-> $fell(sig_clk_o));

    // R7: the replayed byte stays put for a whole frame
    a_r7_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_int != RX_FRAME - 1) |=> $stable(hold));

    // R8: output quiet with common mode off
    a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ccs_en_i |=> (sig_data_o == 1'b0));

endmodule

// File: rtl/sig_ts16_ccs.sv
// Top: timeslot-16 common signalling insert on transmit, extract on receive,
// each side with its own frame counter and derived 64 kHz clock.
// Assumes: ccs_en_i and tx_src_sel_i are configuration levels, changed only
// at frame boundaries; SLOTS and SYS_PER_BIT*SLOTS are even powers of two.
module sig_ts16_ccs
    import sig_ts16_pkg::*;
#(
    parameter int SLOTS       = 32,
    parameter int BITS        = 8,
    parameter int SIG_SLOT    = 16,
    parameter int SYS_PER_BIT = 2
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic ccs_en_i,
    input  logic tx_src_sel_i,
    input  logic sys_data_i,
    input  logic sig_ser_i,
    output logic tx_line_o,
    output logic tx_sig_clk_o,
    input  logic rx_line_i,
    output logic rx_sig_data_o,
    output logic rx_sig_clk_o
);

    localparam int TX_FRAME = SLOTS * BITS * SYS_PER_BIT;
    localparam int RX_FRAME = SLOTS * BITS;
    localparam int TCW      = $clog2(TX_FRAME);
    localparam int RCW      = $clog2(RX_FRAME);

    logic [TCW-1:0] tx_cnt;
    logic [RCW-1:0] rx_cnt;
    ts16_src_e      src_sel;

    assign src_sel = ts16_src_e'(tx_src_sel_i);

    sig_frame_counter #(.LEN(TX_FRAME), .CW(TCW)) u_tx_cnt (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .cnt_o (tx_cnt)
    );

    sig_frame_counter #(.LEN(RX_FRAME), .CW(RCW)) u_rx_cnt (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .cnt_o (rx_cnt)
    );

    sig_ts16_tx #(
        .SLOTS(SLOTS), .BITS(BITS), .SIG_SLOT(SIG_SLOT),
        .SYS_PER_BIT(SYS_PER_BIT), .CW(TCW)
    ) u_tx (
        .clk        (sys_clk),
        .rst_n      (sys_rst_n),
        .cnt_i      (tx_cnt),
        .ccs_en_i   (ccs_en_i),
        .src_i      (src_sel),
        .sys_data_i (sys_data_i),
        .sig_ser_i  (sig_ser_i),
        .tx_line_o  (tx_line_o),
        .sig_clk_o  (tx_sig_clk_o)
    );

    sig_ts16_rx #(
        .SLOTS(SLOTS), .BITS(BITS), .SIG_SLOT(SIG_SLOT), .CW(RCW)
    ) u_rx (
        .clk        (rx_clk),
        .rst_n      (rx_rst_n),
        .cnt_i      (rx_cnt),
        .ccs_en_i   (ccs_en_i),
        .line_i     (rx_line_i),
        .sig_data_o (rx_sig_data_o),
        .sig_clk_o  (rx_sig_clk_o)
    );

    // R9: clock outputs high while either side is held in reset
    a_r9_tx_clk_reset: assert property (@(posedge sys_clk)
        $past(!sys_rst_n) |-> tx_sig_clk_o);

endmodule

// File: tb/sim_sig_ts16_ccs.sv
// Scoreboard bench: transmit driver pushes expected line bits into a queue,
// transmit monitor pops and compares; receive side is compared per cycle.
module sim_sig_ts16_ccs;

    localparam int CLK_PERIOD = 10;
    localparam int RX_PERIOD  = 20;
    localparam int TX_FRAME   = 512;
    localparam int RX_FRAME   = 256;
    localparam int N_FRAMES   = 12;

    logic sys_clk, rx_clk, sys_rst_n, rx_rst_n;
    logic ccs_en, src_sel, sys_data, sig_ser, rx_line;
    logic tx_line, tx_sig_clk, rx_sig_data, rx_sig_clk;

    int checks = 0;
    int fails  = 0;
    bit tx_done = 0;
    bit rx_done = 0;
    bit ccs_at_edge = 0;

    bit    q_exp[$];
    string q_tag[$];

    sig_ts16_ccs u0 (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
        .ccs_en_i(ccs_en), .tx_src_sel_i(src_sel),
        .sys_data_i(sys_data), .sig_ser_i(sig_ser),
        .tx_line_o(tx_line), .tx_sig_clk_o(tx_sig_clk),
        .rx_line_i(rx_line), .rx_sig_data_o(rx_sig_data),
        .rx_sig_clk_o(rx_sig_clk)
    );

    initial begin
        sys_clk = 0;
        forever #(CLK_PERIOD/2) sys_clk = ~sys_clk;
    end

    initial begin
        rx_clk = 0;
        #2;
        forever #(RX_PERIOD/2) rx_clk = ~rx_clk;
    end

    // mode seen by the receive side at each of its edges (never changes there)
    always @(posedge rx_clk) ccs_at_edge = ccs_en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic push_exp(input bit e, input string tag);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic pop_check(input logic act);
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(act === e, t, int'(act), int'(e));
    endtask

    // Transmit driver and monitor
    initial begin
        int tcnt;
        int frame;
        logic [15:0] lf;
        logic [7:0] cur, prev;
        lf = 16'hACE1; cur = 8'h00; prev = 8'h00;
        sys_rst_n = 0; ccs_en = 0; src_sel = 0; sys_data = 0; sig_ser = 0;
        repeat (4) @(negedge sys_clk);
        chk(tx_line === 1'b0, "R9 tx_line", int'(tx_line), 0);
        chk(tx_sig_clk === 1'b1, "R9 tx_clk", int'(tx_sig_clk), 1);
        sys_rst_n = 1;
        tcnt = 0; frame = 0;
        while (frame < N_FRAMES) begin
            // monitor: line bit produced on the previous (even) edge
            if (tcnt % 2 == 1) pop_check(tx_line);
            if (tcnt % 8 == 3)
                chk(tx_sig_clk === ((tcnt % 64) < 32), "R4",
                    int'(tx_sig_clk), int'((tcnt % 64) < 32));
            // driver: frame start sets mode and serial byte
            if (tcnt == 0) begin
                ccs_en  = !(frame < 2 || frame == 8);
                src_sel = (frame >= 4);
                prev = cur;
                lf = step(lf);
                cur = (frame == 4) ? 8'h80 : (frame == 5) ? 8'h01 : lf[7:0];
            end
            if (tcnt % 64 == 0)  sig_ser = cur[7 - tcnt / 64];
            if (frame >= 6 && tcnt % 64 == 24) sig_ser = ~cur[7 - tcnt / 64];
            if (tcnt % 2 == 0) begin
                int b;
                int slot;
                b = tcnt / 2;
                slot = b / 8;
                lf = step(lf);
                sys_data = (frame == 3) ? 1'b1 : lf[0];
                if (ccs_en && src_sel && slot == 16)
                    push_exp(prev[7 - (b % 8)], (frame >= 7) ? "R3/R5" : "R3");
                else if (ccs_en && slot == 16)
                    push_exp(sys_data, "R2");
                else
                    push_exp(sys_data, "R1");
            end
            @(negedge sys_clk);
            tcnt++;
            if (tcnt == TX_FRAME) begin
                tcnt = 0;
                frame++;
            end
        end
        tx_done = 1;
    end

    // Receive driver and checker
    initial begin
        int rcnt;
        bit started;
        logic [15:0] lr;
        logic [7:0] rcur, rhold;
        logic rexp;
        lr = 16'h1D2B; rcur = 0; rhold = 0; rexp = 0; started = 0;
        rx_rst_n = 0; rx_line = 0;
        repeat (4) @(negedge rx_clk);
        chk(rx_sig_data === 1'b0, "R9 rx_data", int'(rx_sig_data), 0);
        chk(rx_sig_clk === 1'b1, "R9 rx_clk", int'(rx_sig_clk), 1);
        rx_rst_n = 1;
        rcnt = 0;
        while (!tx_done) begin
            if (started) begin
                int pr;
                pr = (rcnt + RX_FRAME - 1) % RX_FRAME;
                if (!ccs_at_edge)      rexp = 1'b0;
                else if (pr % 32 == 15) rexp = rhold[7 - pr / 32];
                chk(rx_sig_data === rexp, ccs_at_edge ? "R7" : "R8",
                    int'(rx_sig_data), int'(rexp));
                if (rcnt % 4 == 1)
                    chk(rx_sig_clk === ((rcnt % 32) < 16), "R6",
                        int'(rx_sig_clk), int'((rcnt % 32) < 16));
            end
            if (rcnt == 0) rhold = rcur;
            lr = step(lr);
            rx_line = lr[0];
            if (rcnt >= 128 && rcnt < 136) rcur[7 - (rcnt - 128)] = rx_line;
            @(negedge rx_clk);
            rcnt = (rcnt + 1) % RX_FRAME;
            started = 1;
        end
        rx_done = 1;
    end

    initial begin
        wait (tx_done && rx_done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule